// File: doc/BRIEF.md
# Completion Stream Beat Framer

The framer takes completion packets one at a time and lays them out as beats on a wide streaming output. A packet is a short fixed descriptor plus a payload whose length is given in Dwords. The output bus carries one Dword per lane. The descriptor sits in the lowest lanes of the first beat. The payload follows it with no gaps, so each payload word that enters wraps across two output beats. Alongside the data the framer drives a per-lane keep mask, an end-of-packet flag and a per-byte payload enable. The downstream consumer can stall the output through a ready input.

The descriptor and the payload words arrive on two ready/valid inputs. Payload words are as wide as the output bus. Lane i of payload word w holds payload Dword w*LANES+i, and lanes beyond the packet length are ignored. A static strap selects straddle signalling. With the strap set, the end flag is held low and the keep mask reads all ones, and the consumer must rely on the byte enables instead. Only Dword-aligned placement is handled.

Top module: `csf_framer`

## Requirements
- R1: On the first beat of a packet, lane k (k below DESC_DW) carries desc_hdr bits [32k+31:32k]. Payload Dword j of the packet appears in lane (j+DESC_DW) mod LANES of beat (j+DESC_DW) div LANES.
- R2: With the strap clear, bit l of m_tkeep on beat b is 1 exactly when b*LANES+l < len+DESC_DW. The mask is therefore contiguous from lane 0, and it is all ones on every beat except a partial final beat.
- R3: With the strap clear, m_tlast is 1 only on beat ceil((len+DESC_DW)/LANES)-1. A packet that fits in a single beat has m_tlast set on that one beat.
- R4: With straddle_en set, m_tlast reads 0 and m_tkeep reads all ones on every beat. Data and byte enables are unchanged.
- R5: Bits 4l to 4l+3 of m_byte_en are set exactly when lane l holds a payload Dword of the packet. They are never set on descriptor lanes, and the set lanes form one contiguous run.
- R6: A packet with zero payload length yields one beat. That beat has keep 0x7 (strap clear), all byte enables at zero, and m_tlast set.
- R7: Every lane whose keep bit (strap clear) would be 0 carries zero data, including lanes fed by ignored payload-word lanes.
- R8: While m_tvalid is 1 and m_tready is 0, m_tdata, m_tkeep, m_tlast and m_byte_en hold their values and m_tvalid stays 1.
- R9: When the next packet's descriptor and first payload word are already offered, its first beat is presented in the cycle right after the previous final beat is accepted. With m_tready held high, the beats of back-to-back packets are accepted on consecutive cycles.
- R10: Reset clears m_tvalid. m_tvalid stays 0 after reset until a packet is offered.
- R11: A packet of length len produces exactly ceil((len+DESC_DW)/LANES) beats. It accepts one descriptor and exactly ceil(len/LANES) payload words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| straddle_en | input | 1 | Static strap for straddle signalling |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle |
| desc_hdr | input | DESC_DW*32 (96) | Descriptor Dwords, Dword 0 in the low bits |
| desc_len | input | LEN_W (11) | Payload length in Dwords, 0 to MAX_LEN |
| pl_valid | input | 1 | Payload word offered |
| pl_ready | output | 1 | Payload word accepted this cycle |
| pl_data | input | LANES*32 (1024) | Payload word, payload Dword w*LANES+i in lane i |
| m_tdata | output | LANES*32 (1024) | Output beat data |
| m_tkeep | output | LANES (32) | Per-lane keep mask |
| m_tlast | output | 1 | Final beat of packet |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Consumer ready |
| m_byte_en | output | LANES*4 (128) | Per-byte payload enable |

## Verification
The bench builds the framer with its defaults: LANES=32, DESC_DW=3 and MAX_LEN=1024. This puts the full 33-beat maximum packet in range. It also covers every final-beat fill: a single-beat packet, a lone carry-only final beat (lengths 30 to 32 and 62 to 64), and a beat filled exactly to the last lane. Payload lanes past the length are filled with random data so the zeroing of unused lanes can be seen. Output backpressure is random and sometimes heavy, and the straddle strap is exercised both ways.

// File: rtl/csf_pkg.sv
package csf_pkg;

  localparam int unsigned DWORD_W  = 32;
  localparam int unsigned DW_BYTES = 4;

  // Ceiling division on small unsigned counts.
  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Output beats needed for a packet of len payload Dwords.
  function automatic int unsigned beats_for(input int unsigned len,
                                            input int unsigned desc_dw,
                                            input int unsigned lanes);
    return cdiv(len + desc_dw, lanes);
  endfunction

  // Full-width payload words needed for len payload Dwords.
  function automatic int unsigned words_for(input int unsigned len,
                                            input int unsigned lanes);
    return cdiv(len, lanes);
  endfunction

endpackage

// File: rtl/csf_seq.sv
module csf_seq
  import csf_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int DESC_DW = 3,
  parameter int LEN_W   = 11,
  parameter int IDX_W   = 6,
  parameter int WCNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             desc_valid,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             pl_valid,
  output logic             step,
  output logic             take_desc,
  output logic             take_word,
  output logic             use_word,
  output logic             first,
  output logic             is_last,
  output logic [IDX_W-1:0] cur_idx,
  output logic [LEN_W-1:0] cur_len
);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q;
  logic [WCNT_W-1:0] wleft_q;

  logic [WCNT_W-1:0] words_rem;
  logic [IDX_W-1:0]  last_idx;
  logic              can_go;

  always_comb begin
    cur_len   = active_q ? len_q : desc_len;
    cur_idx   = active_q ? idx_q : '0;
    words_rem = active_q ? wleft_q
                         : WCNT_W'(words_for(32'(desc_len), LANES));
    last_idx  = IDX_W'(beats_for(32'(cur_len), DESC_DW, LANES) - 1);
    use_word  = (words_rem != '0);
    can_go    = (active_q || desc_valid) && (!use_word || pl_valid);
  end

  assign step      = load && can_go;
  assign take_desc = step && !active_q;
  assign take_word = step && use_word;
  assign first     = !active_q;
  assign is_last   = (cur_idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      wleft_q  <= '0;
    end else if (step) begin
      active_q <= !is_last;
      idx_q    <= cur_idx + 1'b1;
      len_q    <= cur_len;
      wleft_q  <= words_rem - WCNT_W'(use_word);
    end
  end

  // At most the final payload word may still be pending on a final beat.
  AST_WORDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    step && is_last |-> words_rem <= WCNT_W'(1)); // R11

  // A new descriptor is only taken once the previous packet has ended.
  AST_DESC_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    step && !is_last |=> !desc_ready_int); // R11

  logic desc_ready_int;
  assign desc_ready_int = take_desc;

endmodule

// File: rtl/csf_lane_mask.sv
module csf_lane_mask
  import csf_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int DESC_DW = 3,
  parameter int LEN_W   = 11,
  parameter int IDX_W   = 6
) (
  input  logic [IDX_W-1:0]          beat_idx,
  input  logic [LEN_W-1:0]          pkt_len,
  output logic [LANES-1:0]          keep,
  output logic [LANES*DW_BYTES-1:0] byte_en
);

  localparam int SPAN_W = IDX_W + $clog2(LANES);
  localparam int POS_W  = ((SPAN_W > LEN_W) ? SPAN_W : LEN_W) + 1;

  logic [POS_W-1:0] base;
  logic [POS_W-1:0] limit;
  logic [LANES-1:0] pay;

  assign base  = POS_W'(beat_idx) * POS_W'(LANES);
  assign limit = POS_W'(pkt_len) + POS_W'(DESC_DW);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [POS_W-1:0] pos;
    assign pos     = base + POS_W'(l);
    assign keep[l] = (pos < limit);
    assign pay[l]  = keep[l] && (pos >= POS_W'(DESC_DW));
    assign byte_en[l*DW_BYTES +: DW_BYTES] = {DW_BYTES{pay[l]}};
  end

endmodule

// File: rtl/csf_beat_pack.sv
module csf_beat_pack
  import csf_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int DESC_DW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       first,
  input  logic                       use_word,
  input  logic                       advance,
  input  logic [DESC_DW*DWORD_W-1:0] hdr,
  input  logic [LANES*DWORD_W-1:0]   word,
  input  logic [LANES-1:0]           keep,
  output logic [LANES*DWORD_W-1:0]   beat
);

  localparam int CARRY_W = DESC_DW * DWORD_W;

  logic [CARRY_W-1:0] carry_q;

  // The top DESC_DW lanes of each payload word spill into the next beat.
  always_ff @(posedge clk) begin
    if (!rst_n)
      carry_q <= '0;
    else if (advance && use_word)
      carry_q <= word[LANES*DWORD_W-1 -: CARRY_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DWORD_W-1:0] raw;
    if (l < DESC_DW) begin : g_low
      assign raw = first ? hdr[l*DWORD_W +: DWORD_W] : carry_q[l*DWORD_W +: DWORD_W];
    end else begin : g_high
      assign raw = use_word ? word[(l-DESC_DW)*DWORD_W +: DWORD_W] : '0;
    end
    assign beat[l*DWORD_W +: DWORD_W] = keep[l] ? raw : '0;
  end

endmodule

// File: rtl/csf_framer.sv
module csf_framer
  import csf_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int DESC_DW = 3,
  parameter int MAX_LEN = 1024,
  localparam int DATA_W    = LANES * DWORD_W,
  localparam int BE_W      = LANES * DW_BYTES,
  localparam int HDR_W     = DESC_DW * DWORD_W,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int MAX_BEATS = (MAX_LEN + DESC_DW + LANES - 1) / LANES,
  localparam int IDX_W     = $clog2(MAX_BEATS + 1),
  localparam int MAX_WORDS = (MAX_LEN + LANES - 1) / LANES,
  localparam int WCNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              straddle_en,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [HDR_W-1:0]  desc_hdr,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [DATA_W-1:0] pl_data,
  output logic [DATA_W-1:0] m_tdata,
  output logic [LANES-1:0]  m_tkeep,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [BE_W-1:0]   m_byte_en
);

  // Named internal events.
  logic             load;
  logic             step;
  logic             take_desc;
  logic             take_word;
  logic             use_word;
  logic             first;
  logic             is_last;
  logic [IDX_W-1:0] cur_idx;
  logic [LEN_W-1:0] cur_len;

  logic [LANES-1:0]  keep_nx;
  logic [BE_W-1:0]   be_nx;
  logic [DATA_W-1:0] beat_nx;

  logic              tvalid_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  keep_q;
  logic              last_q;
  logic              first_q;
  logic [BE_W-1:0]   be_q;

  assign load = !tvalid_q || m_tready;

  csf_seq #(
    .LANES(LANES), .DESC_DW(DESC_DW), .LEN_W(LEN_W),
    .IDX_W(IDX_W), .WCNT_W(WCNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load),
    .desc_valid(desc_valid), .desc_len(desc_len), .pl_valid(pl_valid),
    .step(step), .take_desc(take_desc), .take_word(take_word),
    .use_word(use_word), .first(first), .is_last(is_last),
    .cur_idx(cur_idx), .cur_len(cur_len)
  );

  csf_lane_mask #(
    .LANES(LANES), .DESC_DW(DESC_DW), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_mask (
    .beat_idx(cur_idx), .pkt_len(cur_len), .keep(keep_nx), .byte_en(be_nx)
  );

  csf_beat_pack #(
    .LANES(LANES), .DESC_DW(DESC_DW)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .first(first), .use_word(use_word),
    .advance(step), .hdr(desc_hdr), .word(pl_data), .keep(keep_nx),
    .beat(beat_nx)
  );

  assign desc_ready = take_desc;
  assign pl_ready   = take_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvalid_q <= 1'b0;
      data_q   <= '0;
      keep_q   <= '0;
      last_q   <= 1'b0;
      first_q  <= 1'b0;
      be_q     <= '0;
    end else if (load) begin
      tvalid_q <= step;
      if (step) begin
        data_q  <= beat_nx;
        keep_q  <= keep_nx;
        last_q  <= is_last;
        first_q <= first;
        be_q    <= be_nx;
      end
    end
  end

  assign m_tvalid  = tvalid_q;
  assign m_tdata   = data_q;
  assign m_byte_en = be_q;
  assign m_tkeep   = straddle_en ? '1 : keep_q;
  assign m_tlast   = straddle_en ? 1'b0 : last_q;

  // Per-lane view of the byte enables and the keep mask for the checks.
  logic [LANES-1:0]  be_lane;
  logic [LANES-1:0]  be_low;
  logic [DATA_W-1:0] keep_bits;
  for (genvar l = 0; l < LANES; l++) begin : g_view
    assign be_lane[l] = |be_q[l*DW_BYTES +: DW_BYTES];
    assign keep_bits[l*DWORD_W +: DWORD_W] = {DWORD_W{keep_q[l]}};
  end
  assign be_low = be_lane & (~be_lane + 1'b1);

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !m_tvalid); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
      && $stable(m_tlast) && $stable(m_byte_en)); // R8

  AST_KEEP_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> ((keep_q & (keep_q + 1'b1)) == '0)); // R2

  AST_FULL_UNLESS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !last_q |-> (&keep_q)); // R2

  AST_BE_IN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> ((be_lane & ~keep_q) == '0)); // R5

  AST_BE_NO_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && first_q |-> (be_lane[DESC_DW-1:0] == '0)); // R5

  AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (((be_lane + be_low) & be_lane) == '0)); // R5

  AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> ((data_q & ~keep_bits) == '0)); // R7

  AST_STRADDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    straddle_en && m_tvalid |-> !m_tlast && (&m_tkeep)); // R4

endmodule

// File: tb/csf_framer_tb.sv
`timescale 1ns/100ps
module csf_framer_tb;

  localparam int LANES  = 32;
  localparam int DDW    = 3;
  localparam int DATA_W = LANES * 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               straddle_en = 1'b0;
  logic               desc_valid = 1'b0;
  logic               desc_ready;
  logic [DDW*32-1:0]  desc_hdr = '0;
  logic [10:0]        desc_len = '0;
  logic               pl_valid = 1'b0;
  logic               pl_ready;
  logic [DATA_W-1:0]  pl_data = '0;
  logic [DATA_W-1:0]  m_tdata;
  logic [LANES-1:0]   m_tkeep;
  logic               m_tlast;
  logic               m_tvalid;
  logic               m_tready = 1'b0;
  logic [LANES*4-1:0] m_byte_en;

  csf_framer u_dut (
    .clk(clk), .rst_n(rst_n), .straddle_en(straddle_en),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_hdr(desc_hdr),
    .desc_len(desc_len), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_data(pl_data), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_byte_en(m_byte_en)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Stimulus and reference queues.
  logic [DDW*32-1:0]  dq_hdr[$];
  int                 dq_len[$];
  logic [DATA_W-1:0]  pq[$];
  logic [DATA_W-1:0]  ex_data[$];
  logic [LANES-1:0]   ex_keep[$];
  logic               ex_last[$];
  logic [LANES*4-1:0] ex_be[$];
  string              ex_ktag[$];
  string              ex_ltag[$];

  int n_pkts = 0, n_words = 0, n_desc_fire = 0, n_word_fire = 0;
  int rdy_mode = 0;
  bit gapchk = 1'b0, have_prev = 1'b0;
  int last_acc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: builds the expected beats for one packet.
  task automatic push_pkt(input int len, input bit strad);
    int unsigned dw[];
    logic [DDW*32-1:0]  hdr;
    logic [DATA_W-1:0]  w, d;
    logic [LANES-1:0]   k;
    logic [LANES*4-1:0] be;
    int nw, nb;
    dw = new[len + DDW];
    foreach (dw[i]) dw[i] = $urandom;
    for (int i = 0; i < DDW; i++) hdr[i*32 +: 32] = dw[i];
    dq_hdr.push_back(hdr);
    dq_len.push_back(len);
    nw = (len + LANES - 1) / LANES;
    for (int wi = 0; wi < nw; wi++) begin
      for (int i = 0; i < LANES; i++) begin
        int j = wi * LANES + i;
        w[i*32 +: 32] = (j < len) ? dw[DDW + j] : $urandom;
      end
      pq.push_back(w);
    end
    nb = (len + DDW + LANES - 1) / LANES;
    for (int b = 0; b < nb; b++) begin
      d = '0; k = '0; be = '0;
      for (int l = 0; l < LANES; l++) begin
        int p = b * LANES + l;
        if (p < len + DDW) begin
          d[l*32 +: 32] = dw[p];
          k[l] = 1'b1;
          if (p >= DDW) be[l*4 +: 4] = 4'hF;
        end
      end
      ex_data.push_back(d);
      ex_keep.push_back(strad ? '1 : k);
      ex_last.push_back(strad ? 1'b0 : (b == nb - 1));
      ex_be.push_back(be);
      ex_ktag.push_back(strad ? "R4" : (len == 0 ? "R6" : "R2"));
      ex_ltag.push_back(strad ? "R4" : (len == 0 ? "R6" : "R3"));
    end
    n_pkts++;
    n_words += nw;
  endtask

  // Descriptor driver.
  initial begin
    bit fired = 1'b0;
    forever begin
      @(negedge clk);
      if (fired) begin void'(dq_hdr.pop_front()); void'(dq_len.pop_front()); end
      desc_valid = (dq_len.size() > 0);
      if (desc_valid) begin desc_hdr = dq_hdr[0]; desc_len = 11'(dq_len[0]); end
      #2;
      fired = desc_valid && desc_ready;
      if (fired) n_desc_fire++;
    end
  end

  // Payload driver.
  initial begin
    bit fired = 1'b0;
    forever begin
      @(negedge clk);
      if (fired) void'(pq.pop_front());
      pl_valid = (pq.size() > 0);
      if (pl_valid) pl_data = pq[0];
      #2;
      fired = pl_valid && pl_ready;
      if (fired) n_word_fire++;
    end
  end

  // Output ready driver.
  initial begin
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0: m_tready = 1'b1;
        1: m_tready = ($urandom % 2) == 0;
        default: m_tready = ($urandom % 5) == 0;
      endcase
    end
  end

  // Monitor, compared every clock.
  initial begin
    bit pend = 1'b0;
    logic [DATA_W-1:0]  pd;
    logic [LANES-1:0]   pk;
    logic               pl;
    logic [LANES*4-1:0] pb;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (pend) begin
          chk(m_tvalid, "R8", "tvalid held", DATA_W'(m_tvalid), 1);
          chk(m_tdata == pd && m_tkeep == pk && m_tlast == pl && m_byte_en == pb,
              "R8", "beat held", m_tdata, pd);
        end
        if (m_tvalid && m_tready) begin
          if (ex_data.size() == 0) begin
            chk(1'b0, "R11", "extra beat", m_tdata, '0);
          end else begin
            chk(m_tdata == ex_data[0], "R1 R7", "tdata", m_tdata, ex_data[0]);
            chk(m_tkeep == ex_keep[0], ex_ktag[0], "tkeep", DATA_W'(m_tkeep), DATA_W'(ex_keep[0]));
            chk(m_tlast == ex_last[0], ex_ltag[0], "tlast", DATA_W'(m_tlast), DATA_W'(ex_last[0]));
            chk(m_byte_en == ex_be[0], "R5", "byte_en", DATA_W'(m_byte_en), DATA_W'(ex_be[0]));
            void'(ex_data.pop_front()); void'(ex_keep.pop_front());
            void'(ex_last.pop_front()); void'(ex_be.pop_front());
            void'(ex_ktag.pop_front()); void'(ex_ltag.pop_front());
          end
          if (gapchk && have_prev)
            chk(cyc == last_acc + 1, "R9", "accept gap", DATA_W'(cyc), DATA_W'(last_acc + 1));
          have_prev = 1'b1;
          last_acc = cyc;
        end
        pend = m_tvalid && !m_tready;
        pd = m_tdata; pk = m_tkeep; pl = m_tlast; pb = m_byte_en;
      end else begin
        pend = 1'b0;
      end
    end
  end

  task automatic drain();
    while (ex_data.size() != 0 || dq_len.size() != 0 || pq.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int lens[$];
    repeat (4) @(posedge clk);
    @(negedge clk); #2;
    chk(!m_tvalid, "R10", "tvalid in reset", DATA_W'(m_tvalid), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(!m_tvalid, "R10", "tvalid idle after reset", DATA_W'(m_tvalid), 0);

    // Length corners under random backpressure.
    rdy_mode = 1;
    lens = '{0, 1, 2, 28, 29, 30, 31, 32, 33, 61, 62, 64, 93, 1024};
    foreach (lens[i]) push_pkt(lens[i], 1'b0);
    for (int i = 0; i < 10; i++) push_pkt($urandom % 201, 1'b0);
    drain();

    // Back-to-back burst with ready held high.
    rdy_mode = 0;
    repeat (2) @(posedge clk);
    have_prev = 1'b0;
    gapchk = 1'b1;
    lens = '{5, 29, 0, 32, 64, 3, 1024, 30};
    foreach (lens[i]) push_pkt(lens[i], 1'b0);
    drain();
    gapchk = 1'b0;

    // Straddle strap.
    straddle_en = 1'b1;
    rdy_mode = 1;
    lens = '{0, 40, 100, 29, 31};
    foreach (lens[i]) push_pkt(lens[i], 1'b1);
    drain();
    straddle_en = 1'b0;

    // Heavy backpressure.
    rdy_mode = 2;
    push_pkt(70, 1'b0);
    push_pkt(0, 1'b0);
    drain();

    chk(ex_data.size() == 0, "R11", "beats outstanding", DATA_W'(ex_data.size()), 0);
    chk(n_desc_fire == n_pkts, "R11", "descriptors taken", DATA_W'(n_desc_fire), DATA_W'(n_pkts));
    chk(n_word_fire == n_words, "R11", "payload words taken", DATA_W'(n_word_fire), DATA_W'(n_words));
    finish_run();
  end

endmodule